// File: doc/BRIEF.md
# Runahead Entry Gating Controller

This controller sits beside an out-of-order core and decides when the core may leave normal execution and enter a speculative runahead mode, and when it must come back. A request arrives whenever the instruction at the head of the window is a last-level cache miss. The controller then either grants entry, which raises a checkpoint-save pulse and the active flag, or refuses and reports why on a two-bit reason code. Runahead ends when the miss that started it returns. The controller then drops the active flag and raises a checkpoint-restore pulse.

Two kinds of wasteful period are filtered out. A small table records how many cycles each outstanding miss has been in flight. A miss older than a programmable threshold will return soon, so a period started by it would be short, and entry is refused. The controller also counts instructions pseudo-retired during the last period and instructions fetched since that period ended. While fetch has not yet passed the instructions already pre-executed, a new period would only repeat the same work, so entry is refused.

Top module: `rag_ctrl`

## Requirements
- R1: After a synchronous reset, `ra_active`, `ckpt_save` and `ckpt_restore` are 0 and `deny_code` is 00. The age table is empty, the threshold is 400, and both instruction counters are 0.
- R2: A request (`head_miss_vld`) that is not refused sets `ra_active` on the next cycle and raises `ckpt_save` for exactly that one cycle. The requesting tag becomes the trigger tag.
- R3: While active, a return (`miss_ret_vld`) whose tag equals the trigger tag clears `ra_active` on the next cycle and raises `ckpt_restore` for that one cycle. Returns of other tags leave runahead running.
- R4: The age table holds 8 misses. An issue (`miss_iss_vld`) takes a free slot, and the miss reads age 0 on the cycle after the issue edge. The age rises by 1 each cycle and saturates at 65535. A return frees the slot. An issue that arrives while all 8 slots were full before the edge is dropped. A request whose tag is not in the table counts as age 0.
- R5: A request made while not active, whose miss age is strictly greater than the threshold, is refused with code 01. This check takes priority over the overlap check.
- R6: The threshold is written through `thr_wr`/`thr_wdata` and takes effect from the cycle after the write. A request in the same cycle as the write uses the old value.
- R7: The pseudo-retire counter R counts `pretire_pulse` only while active and is cleared on the entry edge. The fetch counter N counts `fetch_pulse` only while not active and is cleared on the exit edge. Both are 16-bit and saturate at 65535.
- R8: A request made while not active, which passes the age check but finds N < R, is refused with code 10.
- R9: A request made while active is refused with code 11 and has no effect. No save pulse is raised, and the trigger tag and counters are unchanged.
- R10: `deny_code` is registered. It shows the outcome of the request of the previous cycle and reads 00 when there was no request or when the request was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_iss_vld | input | 1 | A last-level miss was sent to memory |
| miss_iss_tag | input | TAG_W | Tag of the issued miss |
| head_miss_vld | input | 1 | Head of window is a last-level miss: entry request |
| head_miss_tag | input | TAG_W | Tag of the miss at the head |
| miss_ret_vld | input | 1 | A miss returned from memory |
| miss_ret_tag | input | TAG_W | Tag of the returning miss |
| pretire_pulse | input | 1 | One instruction pseudo-retired |
| fetch_pulse | input | 1 | One instruction fetched |
| thr_wr | input | 1 | Write strobe for the age threshold |
| thr_wdata | input | AGE_W | New age threshold |
| ra_active | output | 1 | Runahead mode is active |
| ckpt_save | output | 1 | One-cycle pulse: take a checkpoint |
| ckpt_restore | output | 1 | One-cycle pulse: restore the checkpoint |
| deny_code | output | 2 | 00 granted/none, 01 miss too old, 10 overlap, 11 busy |

## Verification
The hardest state to reach is a miss age that saturates. The counter has to sit in the table for more than 65535 cycles with the threshold set just below its ceiling, so the bench holds one miss outstanding through a long idle stretch and then requests it. A second hard case is the full table, where a ninth issue must vanish. The bench fills all eight slots, issues one more tag and shows that this tag later reads age 0 while its older neighbours are refused as too old. Overlap refusals need a period with pseudo-retires followed by too few fetches, and these are built up deliberately before a randomized stretch mixes all the strobes.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [1:0] {
    DENY_NONE    = 2'b00,
    DENY_SHORT   = 2'b01,
    DENY_OVERLAP = 2'b10,
    DENY_BUSY    = 2'b11
  } deny_e;
endpackage

// File: rtl/rag_sat_ctr.sv
module rag_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                    q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end
endmodule

// File: rtl/rag_age_trk.sv
module rag_age_trk #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int AGE_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_vld,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             free_vld,
  input  logic [TAG_W-1:0] free_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic [AGE_W-1:0] look_age
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [AGE_W-1:0]   age_q [ENTRIES];
  logic               slot_found;
  logic [IDX_W-1:0]   slot_idx;

  // lowest free slot, judged on the state before this edge
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        slot_found = 1'b1;
        slot_idx   = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        age_q[g] <= '0;
      end else if (alloc_vld && slot_found && slot_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= alloc_tag;
        age_q[g] <= '0;
      end else if (vld_q[g] && free_vld && tag_q[g] == free_tag) begin
        vld_q[g] <= 1'b0;
      end else if (vld_q[g] && age_q[g] != AGE_MAX) begin
        age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    look_hit = 1'b0;
    look_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && tag_q[i] == look_tag) begin
        look_hit = 1'b1;
        look_age = look_age | age_q[i];
      end
    end
  end
endmodule

// File: rtl/rag_ctrl.sv
module rag_ctrl
  import rag_pkg::*;
#(
  parameter int TAG_W       = 6,
  parameter int TRK_ENTRIES = 8,
  parameter int AGE_W       = 16,
  parameter int CNT_W       = 16,
  parameter int THR_DEFAULT = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_iss_vld,
  input  logic [TAG_W-1:0] miss_iss_tag,
  input  logic             head_miss_vld,
  input  logic [TAG_W-1:0] head_miss_tag,
  input  logic             miss_ret_vld,
  input  logic [TAG_W-1:0] miss_ret_tag,
  input  logic             pretire_pulse,
  input  logic             fetch_pulse,
  input  logic             thr_wr,
  input  logic [AGE_W-1:0] thr_wdata,
  output logic             ra_active,
  output logic             ckpt_save,
  output logic             ckpt_restore,
  output logic [1:0]       deny_code
);
  logic             trk_hit;
  logic [AGE_W-1:0] trk_age;
  logic [AGE_W-1:0] thr_q;
  logic [TAG_W-1:0] trig_q;
  logic [CNT_W-1:0] r_cnt;
  logic [CNT_W-1:0] n_cnt;
  deny_e            verdict;
  logic             grant;
  logic             leave;

  rag_age_trk #(
    .ENTRIES(TRK_ENTRIES), .TAG_W(TAG_W), .AGE_W(AGE_W)
  ) u_trk (
    .clk(clk), .rst(rst),
    .alloc_vld(miss_iss_vld), .alloc_tag(miss_iss_tag),
    .free_vld(miss_ret_vld),  .free_tag(miss_ret_tag),
    .look_tag(head_miss_tag),
    .look_hit(trk_hit), .look_age(trk_age)
  );

  always_comb begin
    verdict = DENY_NONE;
    if (head_miss_vld) begin
      if (ra_active)                        verdict = DENY_BUSY;
      else if (trk_hit && trk_age > thr_q)  verdict = DENY_SHORT;
      else if (n_cnt < r_cnt)               verdict = DENY_OVERLAP;
    end
  end

  assign grant = head_miss_vld && !ra_active && verdict == DENY_NONE;
  assign leave = ra_active && miss_ret_vld && miss_ret_tag == trig_q;

  rag_sat_ctr #(.W(CNT_W)) u_rcnt (
    .clk(clk), .rst(rst), .clr(grant),
    .inc(ra_active && pretire_pulse), .q(r_cnt)
  );

  rag_sat_ctr #(.W(CNT_W)) u_ncnt (
    .clk(clk), .rst(rst), .clr(leave),
    .inc(!ra_active && fetch_pulse), .q(n_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_active    <= 1'b0;
      ckpt_save    <= 1'b0;
      ckpt_restore <= 1'b0;
      deny_code    <= DENY_NONE;
      trig_q       <= '0;
      thr_q        <= AGE_W'(THR_DEFAULT);
    end else begin
      ckpt_save    <= grant;
      ckpt_restore <= leave;
      deny_code    <= verdict;
      if (grant)      ra_active <= 1'b1;
      else if (leave) ra_active <= 1'b0;
      if (grant)  trig_q <= head_miss_tag;
      if (thr_wr) thr_q  <= thr_wdata;
    end
  end
endmodule

// File: rtl/rag_ctrl_chk.sv
module rag_ctrl_chk #(
  parameter int AGE_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             head_miss_vld,
  input logic             ra_active,
  input logic             ckpt_save,
  input logic             ckpt_restore,
  input logic [1:0]       deny_code,
  input logic             trk_hit,
  input logic [AGE_W-1:0] trk_age,
  input logic [AGE_W-1:0] thr_q,
  input logic [CNT_W-1:0] r_cnt,
  input logic [CNT_W-1:0] n_cnt
);
  a_r2_save_on_rise: assert property (@(posedge clk) disable iff (rst)
    ckpt_save |-> (ra_active && !$past(ra_active) && deny_code == 2'b00));

  a_r3_restore_on_fall: assert property (@(posedge clk) disable iff (rst)
    ckpt_restore |-> (!ra_active && $past(ra_active)));

  a_r3_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ckpt_save && ckpt_restore));

  a_r5_old_miss_refused: assert property (@(posedge clk) disable iff (rst)
    (head_miss_vld && !ra_active && trk_hit && trk_age > thr_q)
      |=> (deny_code == 2'b01 && !ckpt_save));

  a_r8_overlap_refused: assert property (@(posedge clk) disable iff (rst)
    (head_miss_vld && !ra_active && !(trk_hit && trk_age > thr_q) && n_cnt < r_cnt)
      |=> (deny_code == 2'b10 && !ckpt_save));

  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (head_miss_vld && ra_active) |=> (deny_code == 2'b11 && !ckpt_save));

  a_r10_quiet_code: assert property (@(posedge clk) disable iff (rst)
    !head_miss_vld |=> deny_code == 2'b00);

  a_r7_n_cleared_on_exit: assert property (@(posedge clk) disable iff (rst)
    ckpt_restore |-> n_cnt == '0);

  a_r7_r_cleared_on_entry: assert property (@(posedge clk) disable iff (rst)
    ckpt_save |-> r_cnt == '0);
endmodule

bind rag_ctrl rag_ctrl_chk #(.AGE_W(AGE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .head_miss_vld(head_miss_vld),
  .ra_active(ra_active), .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore),
  .deny_code(deny_code), .trk_hit(trk_hit), .trk_age(trk_age),
  .thr_q(thr_q), .r_cnt(r_cnt), .n_cnt(n_cnt)
);

// File: tb/rag_ctrl_tb.sv
module rag_ctrl_tb;
  localparam int TW = 6;
  localparam int AW = 16;
  localparam int SAT = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 0, hv = 0, rv = 0, pr = 0, fp = 0, tw = 0;
  logic [TW-1:0] it = '0, ht = '0, rt = '0;
  logic [AW-1:0] twd = '0;
  logic act, sav, rst_o;
  logic [1:0] dc;

  always #5 clk = ~clk;

  rag_ctrl u_dut (
    .clk(clk), .rst(rst),
    .miss_iss_vld(iv), .miss_iss_tag(it),
    .head_miss_vld(hv), .head_miss_tag(ht),
    .miss_ret_vld(rv), .miss_ret_tag(rt),
    .pretire_pulse(pr), .fetch_pulse(fp),
    .thr_wr(tw), .thr_wdata(twd),
    .ra_active(act), .ckpt_save(sav), .ckpt_restore(rst_o), .deny_code(dc)
  );

  // behavioural reference
  int m_age [int];
  int m_act, m_sav, m_res, m_deny, m_r, m_n, m_trig, m_thr;
  int vectors = 0, errors = 0;
  string phase = "R1 reset";

  task automatic model_edge();
    int a, code, enter, leave, full;
    if (rst) begin
      m_age.delete();
      m_act = 0; m_sav = 0; m_res = 0; m_deny = 0;
      m_r = 0; m_n = 0; m_trig = 0; m_thr = 400;
      return;
    end
    a = m_age.exists(int'(ht)) ? m_age[int'(ht)] : 0;
    code = 0;
    if (hv) begin
      if (m_act != 0)       code = 3;
      else if (a > m_thr)   code = 1;
      else if (m_n < m_r)   code = 2;
    end
    enter = (hv && code == 0) ? 1 : 0;
    leave = (m_act != 0 && rv && int'(rt) == m_trig) ? 1 : 0;
    full = (m_age.num() >= 8) ? 1 : 0;
    foreach (m_age[k]) if (m_age[k] < SAT) m_age[k] = m_age[k] + 1;
    if (rv && m_age.exists(int'(rt))) m_age.delete(int'(rt));
    if (iv && full == 0) m_age[int'(it)] = 0;
    if (enter != 0) m_r = 0;
    else if (m_act != 0 && pr && m_r < SAT) m_r++;
    if (leave != 0) m_n = 0;
    else if (m_act == 0 && fp && m_n < SAT) m_n++;
    if (tw) m_thr = int'(twd);
    m_sav = enter; m_res = leave; m_deny = code;
    if (enter != 0) begin m_act = 1; m_trig = int'(ht); end
    else if (leave != 0) m_act = 0;
  endtask

  function automatic string deny_req(int c);
    case (c)
      1: return "R5";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (int'(act) != m_act) begin
      errors++;
      $display("FAIL R2 [%s] ra_active got %0d exp %0d", phase, act, m_act);
    end
    if (int'(sav) != m_sav) begin
      errors++;
      $display("FAIL R2 [%s] ckpt_save got %0d exp %0d", phase, sav, m_sav);
    end
    if (int'(rst_o) != m_res) begin
      errors++;
      $display("FAIL R3 [%s] ckpt_restore got %0d exp %0d", phase, rst_o, m_res);
    end
    if (int'(dc) != m_deny) begin
      errors++;
      $display("FAIL %s [%s] deny_code got %0d exp %0d", deny_req(m_deny), phase, dc, m_deny);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    iv = 0; hv = 0; rv = 0; pr = 0; fp = 0; tw = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1; idle(3); rst = 0;
  endtask

  task automatic issue(int t);   iv = 1; it = TW'(t); step(); endtask
  task automatic request(int t); hv = 1; ht = TW'(t); step(); endtask
  task automatic retn(int t);    rv = 1; rt = TW'(t); step(); endtask
  task automatic set_thr(int v); tw = 1; twd = AW'(v); step(); endtask

  initial begin
    @(negedge clk);
    phase = "R1 reset state";
    do_reset();
    idle(2);

    phase = "R2 entry and R7 pseudo-retire count";
    issue(3); idle(5); request(3);
    for (int i = 0; i < 4; i++) begin pr = 1; step(); end
    phase = "R9 request while active";
    request(3); request(9);
    phase = "R3 foreign return keeps running";
    retn(5); idle(2);
    phase = "R3 trigger return exits";
    retn(3); idle(2);

    phase = "R8 overlap refused";
    issue(7); request(7);
    for (int i = 0; i < 3; i++) begin fp = 1; step(); end
    request(7);
    fp = 1; step();
    phase = "R8 fetch caught up, entry";
    request(7); idle(2); retn(7); idle(1);

    phase = "R5 old miss refused";
    issue(9); pr = 0; idle(405); request(9);
    phase = "R6 raised threshold";
    set_thr(1000); request(9); idle(1); retn(9); idle(1);
    phase = "R6 same-cycle write uses old value";
    set_thr(10); issue(11); idle(15);
    tw = 1; twd = AW'(100); hv = 1; ht = TW'(11); step();
    request(11); idle(1); retn(11); idle(1);

    phase = "R4 full table drops ninth issue";
    do_reset();
    for (int i = 20; i < 28; i++) issue(i);
    issue(28); idle(410);
    request(20); request(28); idle(2); retn(28);
    retn(21); issue(29); idle(3); request(29); idle(1); retn(29);
    phase = "R5 priority over R8";
    issue(30); request(30);
    for (int i = 0; i < 3; i++) begin pr = 1; step(); end
    retn(30); issue(31); idle(402); request(31); request(32); idle(1);

    phase = "R4 age saturation";
    do_reset();
    set_thr(65534); issue(1); idle(65540); request(1);
    set_thr(65535); request(1); idle(1); retn(1); idle(1);

    phase = "R7 R10 randomized mix";
    do_reset(); set_thr(30);
    for (int i = 0; i < 2000; i++) begin
      int t;
      t = int'($urandom_range(15));
      if (!m_age.exists(t) && $urandom_range(3) == 0) begin iv = 1; it = TW'(t); end
      if ($urandom_range(5) == 0) begin hv = 1; ht = TW'($urandom_range(15)); end
      if ($urandom_range(6) == 0) begin
        rv = 1;
        rt = (m_act != 0 && $urandom_range(1) == 0) ? TW'(m_trig) : TW'($urandom_range(15));
        if (iv && rt == it) rv = 0;
      end
      pr = ($urandom_range(1) == 0);
      fp = ($urandom_range(2) == 0);
      if ($urandom_range(200) == 0) begin tw = 1; twd = AW'($urandom_range(60)); end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired in [%s]", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule